// File: doc/BRIEF.md
# Dual-Modulus 32/33 Clock Divider

This block divides its input clock by 32 or by 33, chosen by a single modulus select input. It is the fast front end of a pulse-swallow frequency synthesizer loop. The division is split into two parts. A small fast state machine runs on every input clock and closes a sub-period after 4 clocks, or after 5 clocks when asked to stretch. A three-stage divide-by-8 chain advances once per sub-period. While the chain is in its eighth sub-period it raises a terminal flag. That flag, gated by the modulus captured for the current output period, makes the fast machine stretch that one sub-period. The result is 8 x 4 = 32 input clocks per output period, or 7 x 4 + 5 = 33.

The fast machine has five states. PH_A, PH_B, PH_C and PH_D are the four base phases. PH_X is the extra phase. Its transitions are: PH_A to PH_B, PH_B to PH_C, PH_C to PH_D. From PH_D it goes back to PH_A when not stretching (the "close" transition) or on to PH_X when stretching (the "stretch" transition). PH_X always goes to PH_A (the "swallow-close" transition). Every transition into PH_A is a sub-period tick.

The modulus select is captured once per output period, at the tick that wraps the divide-by-8 chain from 7 back to 0. It is also captured continuously while reset is held. The divided clock is the inverted top bit of the chain. It rises exactly at the wrap, so each output period starts on a rising edge.

Top module: `dual_mod_prescaler`

## Requirements
- R1: With the modulus select held low, consecutive rising edges of the divided clock are exactly 32 input clock cycles apart.
- R2: With the modulus select held high, consecutive rising edges of the divided clock are exactly 33 input clock cycles apart.
- R3: The modulus select is sampled only at the input clock edge that starts an output period. A pulse on it that starts and ends inside a period changes neither that period nor the next one.
- R4: A new modulus select level is first used for the period that starts at the first period start after the change. A change made one input clock before a period start already applies to the period that follows it.
- R5: The divided clock is high for exactly 16 input clocks from each rising edge, whichever modulus is in use.
- R6: The terminal flag output is high only during the eighth sub-period of each output period. It lasts 4 input clocks for modulus 32 and 5 for modulus 33, and it falls on the same edge where the divided clock rises.
- R7: While the active-low synchronous reset is sampled low, the divided clock is 1 and the terminal flag is 0. The first rising edge after release comes a full period (32 or 33 clocks, per the select held during reset) after the release edge.
- R8: The extra input clock of a divide-by-33 period falls in the low phase of the divided clock, inside the terminal sub-period. For modulus 33 the low time is 17 clocks; for modulus 32 it is 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| mod_sel | input | 1 | Modulus select: 0 divides by 32, 1 divides by 33 |
| div_out | output | 1 | Divided clock; a rising edge marks the start of each output period |
| last_sub | output | 1 | Terminal flag of the divide-by-8 chain (eighth sub-period) |

## Verification
The capture of the modulus select and the wrap of the divide-by-8 chain happen on the same input clock edge. A select change that lands right at that edge is the delicate case. The bench provokes it by moving the select on the last clock before a period starts, in both directions. It then judges by the lengths of the current period and the following one: the current period must keep its old length and the next must take the new one. Stretch and wrap also coincide in PH_X. The bench judges this through the split of the 33 clocks into 16 high and 17 low, and a 5-clock terminal flag.

// File: rtl/pscl_pkg.sv
`timescale 1ns/1ps
package pscl_pkg;

    // Base division of the fast stage and number of slow stages.
    localparam int unsigned FAST_BASE   = 4;
    localparam int unsigned SLOW_STAGES = 3;
    localparam int unsigned SLOW_COUNT  = 1 << SLOW_STAGES;

    // Phases of the fast sub-period machine.
    typedef enum logic [2:0] {
        PH_A = 3'd0,
        PH_B = 3'd1,
        PH_C = 3'd2,
        PH_D = 3'd3,
        PH_X = 3'd4
    } fast_phase_t;

endpackage

// File: rtl/pscl_fast_fsm.sv
`timescale 1ns/1ps
module pscl_fast_fsm
    import pscl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stretch,
    output logic tick,
    output logic in_extra
);

    fast_phase_t phase_q;
    fast_phase_t phase_d;

    // Next-phase selection.
    always_comb begin
        phase_d = PH_A;
        unique case (phase_q)
            PH_A: phase_d = PH_B;
            PH_B: phase_d = PH_C;
            PH_C: phase_d = PH_D;
            PH_D: phase_d = stretch ? PH_X : PH_A;
            PH_X: phase_d = PH_A;
            default: phase_d = PH_A;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_A;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Outputs: tick on every transition back into PH_A.
    always_comb begin
        tick     = 1'b0;
        in_extra = 1'b0;
        unique case (phase_q)
            PH_A, PH_B, PH_C: tick = 1'b0;
            PH_D: tick = !stretch;
            PH_X: begin
                tick     = 1'b1;
                in_extra = 1'b1;
            end
            default: tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/pscl_slow_chain.sv
`timescale 1ns/1ps
module pscl_slow_chain #(
    parameter int unsigned STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic top_bit,
    output logic terminal,
    output logic wrap
);

    logic [STAGES-1:0] bit_q;
    logic [STAGES:0]   carry;

    assign carry[0] = tick;

    // Each stage toggles when every lower stage is at 1 and a tick arrives,
    // the single-clock equivalent of a ripple chain fed by the fast stage.
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        assign carry[i+1] = carry[i] & bit_q[i];
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q[i] <= 1'b0;
            end else if (carry[i]) begin
                bit_q[i] <= ~bit_q[i];
            end
        end
    end

    assign top_bit  = bit_q[STAGES-1];
    assign terminal = &bit_q;
    assign wrap     = carry[STAGES];

endmodule

// File: rtl/pscl_mode_gate.sv
`timescale 1ns/1ps
module pscl_mode_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic mod_sel,
    input  logic wrap,
    input  logic terminal,
    output logic mode_q,
    output logic stretch
);

    // Capture the modulus at each period start, and continuously in reset.
    always_ff @(posedge clk) begin
        if (!rst_n || wrap) begin
            mode_q <= mod_sel;
        end
    end

    assign stretch = mode_q & terminal;

endmodule

// File: rtl/dual_mod_prescaler.sv
`timescale 1ns/1ps
module dual_mod_prescaler
    import pscl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mod_sel,
    output logic div_out,
    output logic last_sub
);

    logic tick;
    logic in_extra;
    logic stretch;
    logic top_bit;
    logic terminal;
    logic wrap;
    logic mode_q;

    pscl_fast_fsm u_fast (
        .clk      (clk),
        .rst_n    (rst_n),
        .stretch  (stretch),
        .tick     (tick),
        .in_extra (in_extra)
    );

    pscl_slow_chain #(
        .STAGES (SLOW_STAGES)
    ) u_slow (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .top_bit  (top_bit),
        .terminal (terminal),
        .wrap     (wrap)
    );

    pscl_mode_gate u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mod_sel  (mod_sel),
        .wrap     (wrap),
        .terminal (terminal),
        .mode_q   (mode_q),
        .stretch  (stretch)
    );

    assign div_out  = ~top_bit;
    assign last_sub = terminal;

endmodule

// File: rtl/pscl_checker.sv
`timescale 1ns/1ps
module pscl_checker (
    input logic clk,
    input logic rst_n,
    input logic div_out,
    input logic last_sub,
    input logic mode_q,
    input logic wrap,
    input logic in_extra
);

    // R3: captured modulus only moves at a period start
    p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(mode_q));

    // R5: divided clock rises only right after the terminal sub-period
    p_rise_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_out) |-> $past(last_sub));

    // R6: terminal flag ends exactly where the divided clock rises
    p_last_ends_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(last_sub) |-> $rose(div_out));

    // R6: the chain wraps only from its terminal sub-period
    p_wrap_needs_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> last_sub);

    // R8: the extra phase appears only in the terminal sub-period of a 33 period
    p_extra_only_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_extra |-> (last_sub && mode_q && !div_out));

    // R7: reset puts the outputs in their idle levels
    p_reset_state_r7: assert property (@(posedge clk)
        !rst_n |=> (div_out && !last_sub));

endmodule

bind dual_mod_prescaler pscl_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_out  (div_out),
    .last_sub (last_sub),
    .mode_q   (mode_q),
    .wrap     (wrap),
    .in_extra (in_extra)
);

// File: tb/dual_mod_prescaler_tb.sv
`timescale 1ns/1ps
module dual_mod_prescaler_tb;

    localparam real CLK_HALF = 2.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mod_sel = 1'b0;
    logic div_out;
    logic last_sub;

    int checks = 0;
    int errors = 0;

    always #(CLK_HALF) clk = ~clk;

    dual_mod_prescaler u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mod_sel  (mod_sel),
        .div_out  (div_out),
        .last_sub (last_sub)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // From a negedge at a rise, count negedges to the next rise.
    // At negedge number 'at' drive 'val'; at 'at+len' restore 'base'.
    task automatic run_period(input int at, input int len, input logic val,
                              input logic base, output int n);
        logic prev;
        prev = div_out;
        n = 0;
        forever begin
            if (n == at) mod_sel = val;
            if (n == at + len) mod_sel = base;
            @(negedge clk);
            n++;
            if (!prev && div_out) break;
            prev = div_out;
        end
    endtask

    // From a negedge at a rise, measure the high time, low time and terminal time.
    task automatic shape(output int hi, output int lo, output int ls);
        logic prev;
        prev = div_out;
        hi = 1; lo = 0; ls = last_sub ? 1 : 0;
        forever begin
            @(negedge clk);
            if (!prev && div_out) break;
            prev = div_out;
            if (div_out) hi++; else lo++;
            if (last_sub) ls++;
        end
    endtask

    task automatic t_reset();
        int n;
        rst_n = 1'b0;
        mod_sel = 1'b0;
        repeat (3) @(negedge clk);
        check(div_out === 1'b1, "R7 div_out in reset", int'(div_out), 1);
        check(last_sub === 1'b0, "R7 last_sub in reset", int'(last_sub), 0);
        rst_n = 1'b1;
        run_period(-1, 0, 1'b0, 1'b0, n);
        check(n == 32, "R7 first period after reset", n, 32);
    endtask

    task automatic t_div32();
        int n;
        for (int k = 0; k < 3; k++) begin
            run_period(-1, 0, 1'b0, 1'b0, n);
            check(n == 32, "R1 period mod low", n, 32);
        end
    endtask

    task automatic t_div33();
        int n;
        mod_sel = 1'b1;
        run_period(-1, 0, 1'b1, 1'b1, n);
        check(n == 32, "R4 current period keeps old modulus", n, 32);
        for (int k = 0; k < 3; k++) begin
            run_period(-1, 0, 1'b1, 1'b1, n);
            check(n == 33, "R2 period mod high", n, 33);
        end
    endtask

    task automatic t_shape();
        int hi, lo, ls, n;
        shape(hi, lo, ls);
        check(hi == 16, "R5 high time mod 33", hi, 16);
        check(lo == 17, "R8 low time mod 33", lo, 17);
        check(ls == 5, "R6 terminal time mod 33", ls, 5);
        mod_sel = 1'b0;
        run_period(-1, 0, 1'b0, 1'b0, n);
        shape(hi, lo, ls);
        check(hi == 16, "R5 high time mod 32", hi, 16);
        check(lo == 16, "R8 low time mod 32", lo, 16);
        check(ls == 4, "R6 terminal time mod 32", ls, 4);
    endtask

    task automatic t_glitch();
        int n;
        run_period(5, 4, 1'b1, 1'b0, n);
        check(n == 32, "R3 high pulse mid period", n, 32);
        run_period(-1, 0, 1'b0, 1'b0, n);
        check(n == 32, "R3 period after high pulse", n, 32);
        mod_sel = 1'b1;
        run_period(-1, 0, 1'b1, 1'b1, n);
        run_period(10, 6, 1'b0, 1'b1, n);
        check(n == 33, "R3 low pulse mid period", n, 33);
        run_period(-1, 0, 1'b1, 1'b1, n);
        check(n == 33, "R3 period after low pulse", n, 33);
    endtask

    task automatic t_boundary();
        int n;
        mod_sel = 1'b0;
        run_period(-1, 0, 1'b0, 1'b0, n);
        run_period(31, 99, 1'b1, 1'b0, n);
        check(n == 32, "R4 late rise keeps current 32", n, 32);
        run_period(-1, 0, 1'b1, 1'b1, n);
        check(n == 33, "R4 late rise applies next", n, 33);
        run_period(32, 99, 1'b0, 1'b1, n);
        check(n == 33, "R4 late fall keeps current 33", n, 33);
        run_period(-1, 0, 1'b0, 1'b0, n);
        check(n == 32, "R4 late fall applies next", n, 32);
    endtask

    task automatic t_reset_high();
        int n;
        @(negedge clk);
        rst_n = 1'b0;
        mod_sel = 1'b1;
        repeat (2) @(negedge clk);
        check(div_out === 1'b1, "R7 div_out in second reset", int'(div_out), 1);
        rst_n = 1'b1;
        run_period(-1, 0, 1'b1, 1'b1, n);
        check(n == 33, "R7 first period after reset mod high", n, 33);
    endtask

    initial begin
        #(CLK_HALF * 2.0 * 150000.0);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_div32();
        t_div33();
        t_shape();
        t_glitch();
        t_boundary();
        t_reset_high();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule